// File: doc/BRIEF.md
# Data-Cache Miss Tracker with Non-Blocking Software Prefetch

This block is the miss-handling front end of a first-level data cache. Each core request arrives with the tag-array lookup result already resolved (`lookup_hit_i`, `lookup_data_i`). Hits and stores are answered one cycle after acceptance. Stores that miss, and uncacheable stores, leave through a write-buffer port. Read misses are tracked in a small table of miss entries. Each entry holds one 64-byte line address and up to a fixed number of waiting targets. A later read miss to a line that is already outstanding is merged into that entry as an extra target instead of issuing a second fill.

Software prefetches never stall the core. Each one is acknowledged in the same cycle slot as a hit, with a data word of all ones, whatever the lookup says. When a cacheable prefetch misses and no entry covers its line, an entry is opened under an internal prefetch marker that is not the core's tag, and a fill is requested. When that fill returns, the prefetch target is retired silently. When an entry already covers the line, the prefetch is simply dropped. Prefetches never raise the hint output that feeds the hardware prefetcher; loads and stores always do.

A returning fill is drained one target per cycle, in the order the targets were allocated. While a fill is draining, the core port is held off. The block asserts `blocked_o` when any entry holds its maximum number of targets or when every entry is in use.

Top module: `l1d_miss_front`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `blocked_o`, `rsp_valid_o`, `fill_req_valid_o`, `wbuf_valid_o` and `pf_hint_valid_o` are all 0.
- R2: A load (cmd 0, or the reserved value 3) accepted in cycle t with `req_uncached_i`=0 and `lookup_hit_i`=1 gives `rsp_valid_o` in cycle t+1, with its tag and `lookup_data_i`.
- R3: A software prefetch (cmd 2) accepted in cycle t gives `rsp_valid_o` in cycle t+1, with its tag and data all ones. This holds for hit or miss, cacheable or not.
- R4: A cacheable prefetch miss whose line (address bits above bit 5) matches a live entry issues no fill and adds no target. That entry's fill then answers only its load targets, and its target count does not rise.
- R5: A cacheable prefetch miss with no matching entry opens a new entry and issues one fill for its line. When that fill returns, no core response is produced.
- R6: A fill accepted in cycle t answers target j of the entry in cycle t+2+j, in allocation order, with `fill_rsp_data_i` and the target's tag. Prefetch targets occupy their slot but produce no response.
- R7: An uncacheable prefetch is acknowledged with all-ones data and produces no fill request and no write-buffer entry.
- R8: Every accepted load or store raises `pf_hint_valid_o` in the next cycle; an accepted prefetch never does.
- R9: When a read merge brings an entry to its maximum target count, `blocked_o` is 1 and `req_ready_o` is 0 from the next cycle until the cycle after that entry's last target is drained.
- R10: When every entry is in use, `blocked_o` is 1 and no request is accepted until an entry frees.
- R11: A store (cmd 1) that misses or is uncacheable appears on the write-buffer port in the next cycle with its address and data. It uses no fill, and the core gets a response with data 0.
- R12: A load miss (or an uncacheable load) opens one entry per distinct line and gives no immediate response. A second miss to the same 64-byte line issues no further fill. `fill_req_line_o` carries address bits above bit 5.
- R13: An entry is freed in the cycle after its last target drains, so a new miss to the same line issues a fresh fill.
- R14: `req_ready_o` is 0 in the cycle after a fill response is accepted, and it stays 0 while that fill drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted this cycle when high |
| req_cmd_i | input | 2 | 0 load, 1 store, 2 software prefetch, 3 treated as load |
| req_addr_i | input | ADDR_W | Byte address |
| req_uncached_i | input | 1 | Uncacheable access |
| req_tag_i | input | TAG_W | Core tag, returned with the response |
| req_wdata_i | input | DATA_W | Store data |
| lookup_hit_i | input | 1 | Tag-array lookup hit for this request |
| lookup_data_i | input | DATA_W | Data word read on a hit |
| rsp_valid_o | output | 1 | Core response valid |
| rsp_tag_o | output | TAG_W | Tag of the answered request |
| rsp_data_o | output | DATA_W | Response data |
| fill_req_valid_o | output | 1 | Line fill request valid |
| fill_req_ready_i | input | 1 | Downstream accepts the fill request |
| fill_req_line_o | output | ADDR_W-6 | Line address of the fill |
| fill_req_id_o | output | IDX_W | Entry index the fill belongs to |
| fill_rsp_valid_i | input | 1 | Fill data returned |
| fill_rsp_ready_o | output | 1 | Fill return accepted when high |
| fill_rsp_id_i | input | IDX_W | Entry index of the returned fill |
| fill_rsp_data_i | input | DATA_W | Returned data word |
| wbuf_valid_o | output | 1 | Write-buffer entry valid |
| wbuf_addr_o | output | ADDR_W | Write-buffer address |
| wbuf_data_o | output | DATA_W | Write-buffer data |
| pf_hint_valid_o | output | 1 | Access hint to the hardware prefetcher |
| pf_hint_addr_o | output | ADDR_W | Hinted address |
| blocked_o | output | 1 | Core port blocked: an entry is full or all entries are busy |

## Verification
The assertions assume that a fill response names an entry whose fill was already issued and is still outstanding, that each such fill returns exactly once, and that `lookup_hit_i` is only meaningful while a request is offered. The stimulus keeps within these limits. It holds `fill_req_ready_i` high and records every issued fill's index from the port. It returns fills only for recorded indices, one at a time, and each only after the previous drain has finished. It offers core requests only when `req_ready_o` is high, sweeping tags and addresses so that responses, hints and write-buffer traffic can be predicted from counts and simple arithmetic.

// File: rtl/l1d_miss_pkg.sv
`timescale 1ns/1ps
package l1d_miss_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD  = 2'd0,
    CMD_STORE = 2'd1,
    CMD_SWPF  = 2'd2,
    CMD_RSVD  = 2'd3
  } core_cmd_e;
endpackage

// File: rtl/l1d_mshr_lookup.sv
`timescale 1ns/1ps
module l1d_mshr_lookup #(
  parameter int N_MSHR = 4,
  parameter int N_TGT  = 4,
  parameter int LINE_W = 26,
  localparam int IDX_W = (N_MSHR > 1) ? $clog2(N_MSHR) : 1,
  localparam int CNT_W = $clog2(N_TGT + 1)
) (
  input  logic [N_MSHR-1:0] vld_i,
  input  logic [LINE_W-1:0] line_i [N_MSHR],
  input  logic [CNT_W-1:0]  cnt_i  [N_MSHR],
  input  logic [LINE_W-1:0] probe_i,
  output logic              match_o,
  output logic [IDX_W-1:0]  match_idx_o,
  output logic [IDX_W-1:0]  free_idx_o,
  output logic              any_full_o,
  output logic              all_busy_o
);
  logic [N_MSHR-1:0] hit_vec, full_vec;

  for (genvar g = 0; g < N_MSHR; g++) begin : g_ent
    assign hit_vec[g]  = vld_i[g] && (line_i[g] == probe_i);
    assign full_vec[g] = vld_i[g] && (cnt_i[g] == CNT_W'(N_TGT));
  end

  // lowest index wins for both match and free slot
  always_comb begin
    match_idx_o = '0;
    free_idx_o  = '0;
    for (int i = N_MSHR - 1; i >= 0; i--) begin
      if (hit_vec[i]) match_idx_o = IDX_W'(i);
      if (!vld_i[i])  free_idx_o  = IDX_W'(i);
    end
  end

  assign match_o    = |hit_vec;
  assign any_full_o = |full_vec;
  assign all_busy_o = &vld_i;
endmodule

// File: rtl/l1d_fill_pick.sv
`timescale 1ns/1ps
module l1d_fill_pick #(
  parameter int N_MSHR = 4,
  localparam int IDX_W = (N_MSHR > 1) ? $clog2(N_MSHR) : 1
) (
  input  logic [N_MSHR-1:0] pend_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_MSHR - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign valid_o = |pend_i;
endmodule

// File: rtl/l1d_miss_front.sv
`timescale 1ns/1ps
module l1d_miss_front
  import l1d_miss_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int N_MSHR     = 4,
  parameter int N_TGT      = 4,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int IDX_W  = (N_MSHR > 1) ? $clog2(N_MSHR) : 1,
  localparam int TP_W   = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int CNT_W  = $clog2(N_TGT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_uncached_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              lookup_hit_i,
  input  logic [DATA_W-1:0] lookup_data_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              fill_req_valid_o,
  input  logic              fill_req_ready_i,
  output logic [LINE_W-1:0] fill_req_line_o,
  output logic [IDX_W-1:0]  fill_req_id_o,
  input  logic              fill_rsp_valid_i,
  output logic              fill_rsp_ready_o,
  input  logic [IDX_W-1:0]  fill_rsp_id_i,
  input  logic [DATA_W-1:0] fill_rsp_data_i,
  output logic              wbuf_valid_o,
  output logic [ADDR_W-1:0] wbuf_addr_o,
  output logic [DATA_W-1:0] wbuf_data_o,
  output logic              pf_hint_valid_o,
  output logic [ADDR_W-1:0] pf_hint_addr_o,
  output logic              blocked_o
);
  // entry table
  logic [N_MSHR-1:0] ent_vld_q, ent_iss_q;
  logic [LINE_W-1:0] ent_line_q [N_MSHR];
  logic [CNT_W-1:0]  ent_cnt_q  [N_MSHR];
  logic [TAG_W-1:0]  tgt_tag_q  [N_MSHR][N_TGT];
  logic [N_TGT-1:0]  tgt_pf_q   [N_MSHR];

  // drain state
  logic              drain_q;
  logic [IDX_W-1:0]  drain_idx_q;
  logic [TP_W-1:0]   drain_ptr_q;
  logic [DATA_W-1:0] drain_data_q;

  logic              match, any_full, all_busy;
  logic [IDX_W-1:0]  match_idx, free_idx, pick_idx;
  logic [LINE_W-1:0] probe_line;

  assign probe_line = req_addr_i[ADDR_W-1:OFF_W];

  l1d_mshr_lookup #(.N_MSHR(N_MSHR), .N_TGT(N_TGT), .LINE_W(LINE_W)) u_lookup (
    .vld_i(ent_vld_q), .line_i(ent_line_q), .cnt_i(ent_cnt_q), .probe_i(probe_line),
    .match_o(match), .match_idx_o(match_idx), .free_idx_o(free_idx),
    .any_full_o(any_full), .all_busy_o(all_busy)
  );

  l1d_fill_pick #(.N_MSHR(N_MSHR)) u_pick (
    .pend_i(ent_vld_q & ~ent_iss_q), .valid_o(fill_req_valid_o), .idx_o(pick_idx)
  );

  assign fill_req_id_o    = pick_idx;
  assign fill_req_line_o  = ent_line_q[pick_idx];
  assign blocked_o        = any_full | all_busy;
  assign req_ready_o      = !blocked_o && !drain_q;
  assign fill_rsp_ready_o = !drain_q;

  // request decode
  logic acc, is_pf, is_st, is_ld, miss, ld_miss, ld_merge, pf_alloc, alloc, to_wbuf;
  assign acc      = req_valid_i && req_ready_o;
  assign is_pf    = req_cmd_i == CMD_SWPF;
  assign is_st    = req_cmd_i == CMD_STORE;
  assign is_ld    = !is_pf && !is_st;
  assign miss     = req_uncached_i || !lookup_hit_i;
  assign ld_miss  = acc && is_ld && miss;
  assign ld_merge = ld_miss && match;
  // prefetch: no merge, no MSHR for uncacheable
  assign pf_alloc = acc && is_pf && !req_uncached_i && !lookup_hit_i && !match;
  assign alloc    = (ld_miss && !match) || pf_alloc;
  assign to_wbuf  = acc && is_st && miss;

  logic [TP_W-1:0] merge_slot;
  logic            drain_last;
  assign merge_slot = TP_W'(ent_cnt_q[match_idx]);
  assign drain_last = (CNT_W'(drain_ptr_q) + CNT_W'(1)) == ent_cnt_q[drain_idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld_q <= '0;
      ent_iss_q <= '0;
      for (int i = 0; i < N_MSHR; i++) begin
        ent_line_q[i] <= '0;
        ent_cnt_q[i]  <= '0;
        tgt_pf_q[i]   <= '0;
        for (int j = 0; j < N_TGT; j++) tgt_tag_q[i][j] <= '0;
      end
    end else begin
      if (fill_req_valid_o && fill_req_ready_i) ent_iss_q[pick_idx] <= 1'b1;
      if (alloc) begin
        ent_vld_q[free_idx]       <= 1'b1;
        ent_iss_q[free_idx]       <= 1'b0;
        ent_line_q[free_idx]      <= probe_line;
        ent_cnt_q[free_idx]       <= CNT_W'(1);
        tgt_tag_q[free_idx][0]    <= is_pf ? '0 : req_tag_i;  // prefetch uses internal marker
        tgt_pf_q[free_idx][0]     <= is_pf;
      end
      if (ld_merge) begin
        tgt_tag_q[match_idx][merge_slot] <= req_tag_i;
        tgt_pf_q[match_idx][merge_slot]  <= 1'b0;
        ent_cnt_q[match_idx]             <= ent_cnt_q[match_idx] + CNT_W'(1);
      end
      if (drain_q && drain_last) ent_vld_q[drain_idx_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q      <= 1'b0;
      drain_idx_q  <= '0;
      drain_ptr_q  <= '0;
      drain_data_q <= '0;
    end else if (drain_q) begin
      if (drain_last) drain_q <= 1'b0;
      else            drain_ptr_q <= drain_ptr_q + TP_W'(1);
    end else if (fill_rsp_valid_i) begin
      drain_q      <= 1'b1;
      drain_idx_q  <= fill_rsp_id_i;
      drain_ptr_q  <= '0;
      drain_data_q <= fill_rsp_data_i;
    end
  end

  // response, write buffer, hint registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_tag_o       <= '0;
      rsp_data_o      <= '0;
      wbuf_valid_o    <= 1'b0;
      wbuf_addr_o     <= '0;
      wbuf_data_o     <= '0;
      pf_hint_valid_o <= 1'b0;
      pf_hint_addr_o  <= '0;
    end else begin
      if (acc) begin
        rsp_valid_o <= !ld_miss;
        rsp_tag_o   <= req_tag_i;
        rsp_data_o  <= is_pf ? '1 : (is_ld ? lookup_data_i : '0);
      end else if (drain_q) begin
        rsp_valid_o <= !tgt_pf_q[drain_idx_q][drain_ptr_q];
        rsp_tag_o   <= tgt_tag_q[drain_idx_q][drain_ptr_q];
        rsp_data_o  <= drain_data_q;
      end else begin
        rsp_valid_o <= 1'b0;
      end
      wbuf_valid_o    <= to_wbuf;
      pf_hint_valid_o <= acc && !is_pf;
      if (to_wbuf) begin
        wbuf_addr_o <= req_addr_i;
        wbuf_data_o <= req_wdata_i;
      end
      if (acc && !is_pf) pf_hint_addr_o <= req_addr_i;
    end
  end
endmodule

// File: rtl/l1d_miss_front_chk.sv
`timescale 1ns/1ps
module l1d_miss_front_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_cmd_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_uncached_i,
  input logic [TAG_W-1:0]  req_tag_i,
  input logic              lookup_hit_i,
  input logic [DATA_W-1:0] lookup_data_i,
  input logic              rsp_valid_o,
  input logic [TAG_W-1:0]  rsp_tag_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              fill_rsp_valid_i,
  input logic              fill_rsp_ready_o,
  input logic              wbuf_valid_o,
  input logic [ADDR_W-1:0] wbuf_addr_o,
  input logic              pf_hint_valid_o,
  input logic              blocked_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  // R2
  load_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_cmd_i == 2'd0 && !req_uncached_i && lookup_hit_i)
      |=> (rsp_valid_o && rsp_tag_o == $past(req_tag_i) && rsp_data_o == $past(lookup_data_i)));

  // R3
  pf_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_cmd_i == 2'd2)
      |=> (rsp_valid_o && rsp_tag_o == $past(req_tag_i) && rsp_data_o == '1));

  // R7
  uc_pf_no_wbuf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_cmd_i == 2'd2 && req_uncached_i) |=> !wbuf_valid_o);

  // R8
  pf_no_hint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_cmd_i == 2'd2) |=> !pf_hint_valid_o);

  // R8
  ldst_hint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_cmd_i != 2'd2) |=> pf_hint_valid_o);

  // R9
  blocked_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blocked_o) |-> $past(acc));

  // R11
  uc_store_wbuf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_cmd_i == 2'd1 && req_uncached_i)
      |=> (wbuf_valid_o && wbuf_addr_o == $past(req_addr_i)));

  // R12
  miss_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (req_cmd_i == 2'd0 || req_cmd_i == 2'd3) && (req_uncached_i || !lookup_hit_i))
      |=> !rsp_valid_o);

  // R14
  drain_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_rsp_valid_i && fill_rsp_ready_o) |=> !req_ready_o);
endmodule

bind l1d_miss_front l1d_miss_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_uncached_i(req_uncached_i),
  .req_tag_i(req_tag_i), .lookup_hit_i(lookup_hit_i), .lookup_data_i(lookup_data_i),
  .rsp_valid_o(rsp_valid_o), .rsp_tag_o(rsp_tag_o), .rsp_data_o(rsp_data_o),
  .fill_rsp_valid_i(fill_rsp_valid_i), .fill_rsp_ready_o(fill_rsp_ready_o),
  .wbuf_valid_o(wbuf_valid_o), .wbuf_addr_o(wbuf_addr_o),
  .pf_hint_valid_o(pf_hint_valid_o), .blocked_o(blocked_o)
);

// File: tb/l1d_miss_front_bench.sv
`timescale 1ns/1ps
module l1d_miss_front_bench;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, PF = 2'd2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_uncached_i = 1'b0, lookup_hit_i = 1'b0;
  logic [1:0]  req_cmd_i = '0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0, lookup_data_i = '0;
  logic [3:0]  req_tag_i = '0;
  logic fill_req_ready_i = 1'b1, fill_rsp_valid_i = 1'b0;
  logic [1:0]  fill_rsp_id_i = '0;
  logic [31:0] fill_rsp_data_i = '0;
  logic req_ready_o, rsp_valid_o, fill_req_valid_o, fill_rsp_ready_o;
  logic wbuf_valid_o, pf_hint_valid_o, blocked_o;
  logic [3:0]  rsp_tag_o;
  logic [31:0] rsp_data_o, wbuf_addr_o, wbuf_data_o, pf_hint_addr_o;
  logic [25:0] fill_req_line_o;
  logic [1:0]  fill_req_id_o;

  always #2 clk = ~clk;

  l1d_miss_front u_l1d_miss_front (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_uncached_i(req_uncached_i),
    .req_tag_i(req_tag_i), .req_wdata_i(req_wdata_i), .lookup_hit_i(lookup_hit_i),
    .lookup_data_i(lookup_data_i), .rsp_valid_o(rsp_valid_o), .rsp_tag_o(rsp_tag_o),
    .rsp_data_o(rsp_data_o), .fill_req_valid_o(fill_req_valid_o),
    .fill_req_ready_i(fill_req_ready_i), .fill_req_line_o(fill_req_line_o),
    .fill_req_id_o(fill_req_id_o), .fill_rsp_valid_i(fill_rsp_valid_i),
    .fill_rsp_ready_o(fill_rsp_ready_o), .fill_rsp_id_i(fill_rsp_id_i),
    .fill_rsp_data_i(fill_rsp_data_i), .wbuf_valid_o(wbuf_valid_o), .wbuf_addr_o(wbuf_addr_o),
    .wbuf_data_o(wbuf_data_o), .pf_hint_valid_o(pf_hint_valid_o),
    .pf_hint_addr_o(pf_hint_addr_o), .blocked_o(blocked_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // port monitors, sampled 1 ns after the falling edge
  int rsp_n = 0, fill_n = 0, wbuf_n = 0, hint_n = 0;
  logic [3:0]  rsp_tag_log  [256];
  logic [31:0] rsp_data_log [256];
  logic [1:0]  fill_id_log  [64];
  logic [25:0] fill_line_log[64];
  logic [31:0] wbuf_addr_log[64], wbuf_data_log[64];

  always begin
    @(negedge clk);
    #1;
    if (rst_ni) begin
      if (rsp_valid_o) begin
        rsp_tag_log[rsp_n] = rsp_tag_o; rsp_data_log[rsp_n] = rsp_data_o; rsp_n++;
      end
      if (fill_req_valid_o && fill_req_ready_i) begin
        fill_id_log[fill_n] = fill_req_id_o; fill_line_log[fill_n] = fill_req_line_o; fill_n++;
      end
      if (wbuf_valid_o) begin
        wbuf_addr_log[wbuf_n] = wbuf_addr_o; wbuf_data_log[wbuf_n] = wbuf_data_o; wbuf_n++;
      end
      if (pf_hint_valid_o) hint_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] cmd, input logic [31:0] addr, input bit unc,
                       input logic [3:0] tag, input bit hit, input logic [31:0] data);
    int guard = 0;
    while (!req_ready_o && guard < 50) begin @(negedge clk); guard++; end
    req_valid_i = 1'b1; req_cmd_i = cmd; req_addr_i = addr; req_uncached_i = unc;
    req_tag_i = tag; lookup_hit_i = hit; lookup_data_i = data; req_wdata_i = data;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic fill_line(input logic [1:0] id, input logic [31:0] data, input int ntgt);
    fill_rsp_valid_i = 1'b1; fill_rsp_id_i = id; fill_rsp_data_i = data;
    @(posedge clk); @(negedge clk);
    fill_rsp_valid_i = 1'b0;
    chk(!req_ready_o, "R14", "ready during drain", 64'(req_ready_o), 64'd0);
    idle(ntgt + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles got %0d expected < %0d", 200000, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b, f, w, h, id;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready", 64'(req_ready_o), 64'd1);
    chk(!blocked_o && !rsp_valid_o && !fill_req_valid_o && !wbuf_valid_o && !pf_hint_valid_o,
        "R1", "idle outputs", {blocked_o, rsp_valid_o, fill_req_valid_o, wbuf_valid_o, pf_hint_valid_o}, 64'd0);

    // R2 load hit sweep over all tags
    b = rsp_n; h = hint_n; f = fill_n;
    for (int t = 0; t < 16; t++) issue(LD, 32'h100 + 32'(t) * 4, 0, 4'(t), 1, 32'h1000_0000 + 32'(t) * 32'h111);
    idle(2);
    chk(rsp_n == b + 16, "R2", "hit responses", 64'(rsp_n - b), 64'd16);
    for (int t = 0; t < 16; t++) begin
      chk(rsp_tag_log[b + t] == 4'(t), "R2", "hit tag", 64'(rsp_tag_log[b + t]), 64'(t));
      chk(rsp_data_log[b + t] == 32'h1000_0000 + 32'(t) * 32'h111, "R2", "hit data",
          64'(rsp_data_log[b + t]), 64'(32'h1000_0000 + 32'(t) * 32'h111));
    end
    chk(hint_n == h + 16, "R8", "load hints", 64'(hint_n - h), 64'd16);
    chk(fill_n == f, "R2", "no fill on hit", 64'(fill_n - f), 64'd0);

    // R3/R7 prefetch: cacheable hit, uncached hit, uncached miss
    b = rsp_n; h = hint_n; f = fill_n; w = wbuf_n;
    issue(PF, 32'h400, 0, 4'h2, 1, 32'h0);
    issue(PF, 32'h500, 1, 4'h3, 1, 32'h0);
    issue(PF, 32'h600, 1, 4'h4, 0, 32'h0);
    idle(2);
    chk(rsp_n == b + 3, "R3", "pf acks", 64'(rsp_n - b), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk(rsp_tag_log[b + k] == 4'(k + 2), "R3", "pf ack tag", 64'(rsp_tag_log[b + k]), 64'(k + 2));
      chk(rsp_data_log[b + k] == 32'hFFFF_FFFF, "R3", "pf ack data", 64'(rsp_data_log[b + k]), 64'hFFFF_FFFF);
    end
    chk(fill_n == f, "R7", "no fill for uncached pf", 64'(fill_n - f), 64'd0);
    chk(wbuf_n == w, "R7", "no wbuf for uncached pf", 64'(wbuf_n - w), 64'd0);
    chk(hint_n == h, "R8", "no hint on pf", 64'(hint_n - h), 64'd0);

    // R11 stores: hit, miss, uncached
    b = rsp_n; h = hint_n; f = fill_n; w = wbuf_n;
    issue(ST, 32'h200, 0, 4'h5, 1, 32'h11);
    issue(ST, 32'h240, 0, 4'h6, 0, 32'h55);
    issue(ST, 32'h280, 1, 4'h7, 1, 32'h66);
    idle(2);
    chk(wbuf_n == w + 2, "R11", "wbuf entries", 64'(wbuf_n - w), 64'd2);
    chk(wbuf_addr_log[w] == 32'h240 && wbuf_data_log[w] == 32'h55, "R11", "miss store", 64'(wbuf_addr_log[w]), 64'h240);
    chk(wbuf_addr_log[w + 1] == 32'h280 && wbuf_data_log[w + 1] == 32'h66, "R11", "uc store", 64'(wbuf_addr_log[w + 1]), 64'h280);
    chk(rsp_n == b + 3 && rsp_data_log[b + 1] == 32'h0, "R11", "store responses", 64'(rsp_n - b), 64'd3);
    chk(fill_n == f, "R11", "no fill on store", 64'(fill_n - f), 64'd0);
    chk(hint_n == h + 3, "R8", "store hints", 64'(hint_n - h), 64'd3);

    // R12 load miss, merge; R4 pf onto live line; R5 pf to new line
    b = rsp_n; f = fill_n;
    issue(LD, 32'h1004, 0, 4'h4, 0, 32'h0);
    idle(2);
    chk(rsp_n == b, "R12", "no rsp on miss", 64'(rsp_n - b), 64'd0);
    chk(fill_n == f + 1 && fill_line_log[f] == 26'h40, "R12", "fill line", 64'(fill_line_log[f]), 64'h40);
    id = int'(fill_id_log[f]);
    issue(LD, 32'h1028, 0, 4'h5, 0, 32'h0);
    issue(PF, 32'h1030, 0, 4'h6, 0, 32'h0);
    idle(2);
    chk(fill_n == f + 1, "R4", "no fill for merge/pf", 64'(fill_n - f), 64'd1);
    chk(rsp_n == b + 1 && rsp_data_log[b] == 32'hFFFF_FFFF && rsp_tag_log[b] == 4'h6, "R3", "pf miss ack",
        64'(rsp_data_log[b]), 64'hFFFF_FFFF);
    issue(PF, 32'h2000, 0, 4'h7, 0, 32'h0);
    idle(2);
    chk(fill_n == f + 2 && fill_line_log[f + 1] == 26'h80, "R5", "pf fill line", 64'(fill_line_log[f + 1]), 64'h80);
    chk(rsp_n == b + 2 && rsp_tag_log[b + 1] == 4'h7, "R3", "pf new-line ack", 64'(rsp_n - b), 64'd2);

    // R6 drain in order, R4 no pf target added
    b = rsp_n;
    fill_line(2'(id), 32'hDEAD_BEEF, 2);
    chk(rsp_n == b + 2, "R4", "only load targets answered", 64'(rsp_n - b), 64'd2);
    chk(rsp_tag_log[b] == 4'h4 && rsp_tag_log[b + 1] == 4'h5, "R6", "drain order",
        {rsp_tag_log[b], rsp_tag_log[b + 1]}, 8'h45);
    chk(rsp_data_log[b] == 32'hDEAD_BEEF, "R6", "fill data", 64'(rsp_data_log[b]), 64'hDEAD_BEEF);
    b = rsp_n;
    fill_line(fill_id_log[f + 1], 32'h1, 1);
    chk(rsp_n == b, "R5", "pf fill silent", 64'(rsp_n - b), 64'd0);

    // R13 freed entry reallocates
    b = rsp_n; f = fill_n;
    issue(LD, 32'h1000, 0, 4'h8, 0, 32'h0);
    idle(2);
    chk(fill_n == f + 1 && fill_line_log[f] == 26'h40, "R13", "refill after free", 64'(fill_n - f), 64'd1);
    fill_line(fill_id_log[f], 32'h1234, 1);
    chk(rsp_n == b + 1 && rsp_tag_log[b] == 4'h8, "R13", "refill answered", 64'(rsp_n - b), 64'd1);

    // R9 max targets
    b = rsp_n; f = fill_n;
    issue(LD, 32'h3000, 0, 4'h9, 0, 32'h0);
    issue(LD, 32'h3004, 0, 4'hA, 0, 32'h0);
    issue(LD, 32'h3008, 0, 4'hB, 0, 32'h0);
    issue(PF, 32'h300C, 0, 4'hC, 0, 32'h0);
    chk(!blocked_o && req_ready_o, "R4", "pf adds no target", 64'(blocked_o), 64'd0);
    issue(LD, 32'h3010, 0, 4'hD, 0, 32'h0);
    chk(blocked_o && !req_ready_o, "R9", "blocked at max targets", {blocked_o, req_ready_o}, 64'b10);
    idle(3);
    chk(blocked_o, "R9", "stays blocked", 64'(blocked_o), 64'd1);
    chk(fill_n == f + 1, "R12", "one fill per line", 64'(fill_n - f), 64'd1);
    fill_line(fill_id_log[f], 32'h7777, 4);
    chk(rsp_n == b + 5, "R6", "pf ack + 4 targets", 64'(rsp_n - b), 64'd5);
    chk({rsp_tag_log[b + 1], rsp_tag_log[b + 2], rsp_tag_log[b + 3], rsp_tag_log[b + 4]} == 16'h9ABD,
        "R6", "target order", {rsp_tag_log[b + 1], rsp_tag_log[b + 2], rsp_tag_log[b + 3], rsp_tag_log[b + 4]}, 16'h9ABD);
    chk(!blocked_o && req_ready_o, "R9", "unblocked after free", {blocked_o, req_ready_o}, 64'b01);

    // R10 all entries busy
    b = rsp_n; f = fill_n;
    for (int k = 0; k < 4; k++) begin
      chk(!blocked_o, "R10", "not blocked before full", 64'(blocked_o), 64'd0);
      issue(LD, 32'h1_0000 * 32'(k + 1), 0, 4'(k), 0, 32'h0);
    end
    chk(blocked_o && !req_ready_o, "R10", "blocked when all busy", {blocked_o, req_ready_o}, 64'b10);
    idle(2);
    chk(fill_n == f + 4, "R10", "four fills", 64'(fill_n - f), 64'd4);
    for (int k = 0; k < 4; k++) begin
      chk(fill_line_log[f + k] == 26'(32'h1_0000 * 32'(k + 1) >> 6), "R12", "fill line sweep",
          64'(fill_line_log[f + k]), 64'(32'h1_0000 * 32'(k + 1) >> 6));
      fill_line(fill_id_log[f + k], 32'hC000 + 32'(k), 1);
      chk(rsp_n == b + k + 1 && rsp_data_log[b + k] == 32'hC000 + 32'(k), "R6", "per-entry fill",
          64'(rsp_data_log[b + k]), 64'(32'hC000 + 32'(k)));
    end
    chk(!blocked_o && req_ready_o, "R10", "unblocked after fills", {blocked_o, req_ready_o}, 64'b01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule